// File: doc/BRIEF.md
# RAM/ROM Overlay Bank Selector

This block sits beside a 16-bit processor whose 32K-word address space holds RAM and ROM at the same addresses. It decides, access by access, whether a read is served from ROM or from RAM. It tracks the cycle type the processor announces at the start of each access and the address of each instruction fetch. It also watches the opcode the processor fetches, and keeps a few flags that mark the second memory access of a memory-referencing instruction. A 4-bit mode register and a single overlay bit also feed the decision. Some opcodes that the processor itself ignores load the mode register. While two of the mode bits are set, every instruction fetch recomputes the overlay bit from a 4096 x 8 map table kept inside the block.

The processor raises a one-cycle status strobe carrying the cycle type, then a read or write strobe with the word address, and, for a fetch, an opcode strobe a cycle after the read. The ROM select is registered. Writes always go to RAM and pass through with their byte lanes. A separate write port loads the map table.

Top module: `ovl_bank_sel`

## Requirements
- R1: After reset `rom_sel` and `ram_we` are 0, `ram_be` is 0, the mode register holds 4'hF and the overlay bit is 0.
- R2: `stm_type` is an OR of read 0x01, write 0x02, instruction fetch 0x04, DMA 0x08 and register space 0x10. A read is taken on the first cycle of `rd_en` after a status with the read bit set and the register bit clear. `rom_sel` carries the result from the next clock edge, holds while `rd_en` stays high, and returns to 0 one edge after `rd_en` falls.
- R3: A read goes to RAM (`rom_sel`=0) when the address is in 0x6000..0x7FFF, the cycle has the DMA bit, mode bit 1 is 0, or the address is 0x0400 or above while mode bit 0 is 0.
- R4: If R3 does not apply, ROM is selected for any address in 0x0000..0x03FF, and for an instruction fetch at 0x0800 or above.
- R5: An opcode strobe sets a second-access flag and a memory-reference flag (set when opcode bits 14:12 are not all ones). While both flags are set, a read outside 0x0400..0x07FF, or any read while mode bit 2 is 0, selects ROM. The second-access flag clears when a non-fetch, non-DMA read or write is taken, when a non-DMA register-space status arrives, or when a new fetch status arrives.
- R6: When nothing above applies, a read in 0x0400..0x07FF with mode bit 2 set goes to RAM. Every other read follows the overlay bit.
- R7: An opcode with bits 15:6 equal to 10'h1C1 (opcode & 0xFFC0 == 0x7040) loads opcode bits 3:0 into the mode register. In that case the overlay bit becomes 0 if the new bit 3 is 0. Otherwise it becomes 1 if the new bit 2 is 0.
- R8: On each opcode strobe while mode bits 3 and 2 are both 1, the overlay bit is recomputed from the captured fetch address A. It is 0 if A < 0x20 or A >= 0x6000. Otherwise it is bit (~A[14:12]) of map entry (~A[11:0]).
- R9: A fetch whose address has bits 14:8 equal to 0x09 sets a flag. While that flag and the overlay bit are both set, reads select ROM even in 0x0400..0x07FF.
- R10: A fetch in register space captures no address. The fetch address is then 0, so an R8 recompute clears the overlay bit, and `rd_en` during that cycle leaves `rom_sel` at 0.
- R11: `ram_we` equals `wr_en` one edge later, with `ram_be` equal to the `wr_mask` of that cycle. A write never raises `rom_sel`.
- R12: A `map_we` pulse stores `map_wdata` at entry `map_addr`. Later R8 lookups return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stm_valid | input | 1 | Status strobe at the start of an access |
| stm_type | input | 5 | Cycle type bits |
| addr | input | 15 | Word address of the access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_mask | input | 2 | Byte lanes of the write |
| op_valid | input | 1 | Fetched opcode is present |
| opcode | input | 16 | Fetched opcode |
| map_we | input | 1 | Map table write enable |
| map_addr | input | 12 | Map table write index |
| map_wdata | input | 8 | Map table write data |
| rom_sel | output | 1 | 1 = read from ROM, 0 = read from RAM |
| ram_we | output | 1 | RAM write enable |
| ram_be | output | 2 | RAM byte-lane enables |

## Verification
A status strobe is stored on one edge, and the read strobe uses it on the next, so `rom_sel` is due on the edge after `rd_en` rises and `ram_we`/`ram_be` on the edge after `wr_en`. Opcode strobes change the mode, overlay and flags on their own edge, and the effect shows only on the next read. The bench drives every input on the falling edge and samples each output at the following falling edge, one rising edge after the stimulus. The hold and release of `rom_sel` are checked on each cycle that `rd_en` is held and on the cycle after it drops.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int CYC_W  = 5;
  localparam int CB_RD  = 0;
  localparam int CB_WR  = 1;
  localparam int CB_IF  = 2;
  localparam int CB_DMA = 3;
  localparam int CB_REG = 4;
  localparam int MODE_W = 4;
  localparam int WA_W   = 15;
  localparam logic [9:0] MODE_OP_HI = 10'h1C1;
endpackage

// File: rtl/ovl_map_ram.sv
module ovl_map_ram #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ovl_route_dec.sv
module ovl_route_dec
  import ovl_pkg::*;
(
  input  logic [WA_W-1:0]   a,
  input  logic              is_fetch,
  input  logic              is_dma,
  input  logic [MODE_W-1:0] mode,
  input  logic              ovl,
  input  logic              sec,
  input  logic              mref,
  input  logic              f09,
  output logic              to_rom
);
  logic top_ram, hi_zone, mid_zone, low_zone, force_ram, force_rom;

  always_comb begin
    top_ram   = (a[14:13] == 2'b11);
    hi_zone   = (a[14:11] != 4'd0);
    mid_zone  = !hi_zone && a[10];
    low_zone  = !hi_zone && !a[10];
    force_ram = top_ram || is_dma || !mode[1] || ((a[14:10] != 5'd0) && !mode[0]);
    force_rom = low_zone || (is_fetch && hi_zone) ||
                (sec && mref && (!mode[2] || !mid_zone)) || (ovl && f09);
    if (force_ram)                 to_rom = 1'b0;
    else if (force_rom)            to_rom = 1'b1;
    else if (mid_zone && mode[2])  to_rom = 1'b0;
    else                           to_rom = ovl;
  end
endmodule

// File: rtl/ovl_ctrl.sv
module ovl_ctrl
  import ovl_pkg::*;
#(
  parameter int MAP_DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stm_valid,
  input  logic [CYC_W-1:0]  stm_type,
  input  logic [WA_W-1:0]   addr,
  input  logic              rd_rise,
  input  logic              wr_rise,
  input  logic              op_valid,
  input  logic [15:0]       opcode,
  input  logic [MAP_DW-1:0] map_q,
  output logic              rd_take,
  output logic              map_re,
  output logic              cyc_fetch,
  output logic              cyc_dma,
  output logic [MODE_W-1:0] mode_q,
  output logic              ovl_q,
  output logic              sec_q,
  output logic              mref_q,
  output logic              f09_q
);
  logic [CYC_W-1:0] cyc_q;
  logic [WA_W-1:0]  fa_q;
  logic             wr_take;
  logic             mode_op;
  logic             recompute_zero;
  logic             map_bit;
  logic             unused_op_bits;

  assign cyc_fetch      = cyc_q[CB_IF];
  assign cyc_dma        = cyc_q[CB_DMA];
  assign rd_take        = rd_rise && cyc_q[CB_RD] && !cyc_q[CB_REG];
  assign wr_take        = wr_rise && cyc_q[CB_WR];
  assign map_re         = rd_take && cyc_q[CB_IF];
  assign mode_op        = (opcode[15:6] == MODE_OP_HI);
  assign recompute_zero = (fa_q < 15'h0020) || (fa_q[14:13] == 2'b11);
  assign map_bit        = map_q[~fa_q[14:12]];
  assign unused_op_bits = ^opcode[5:4];

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= '0;
      fa_q   <= '0;
      mode_q <= 4'hF;
      ovl_q  <= 1'b0;
      sec_q  <= 1'b0;
      mref_q <= 1'b0;
      f09_q  <= 1'b0;
    end else begin
      if (stm_valid) begin
        cyc_q <= stm_type;
        if (stm_type[CB_IF]) begin
          sec_q  <= 1'b0;
          mref_q <= 1'b0;
          f09_q  <= 1'b0;
          fa_q   <= '0;
        end else if (stm_type[CB_REG]) begin
          if (!stm_type[CB_DMA]) sec_q <= 1'b0;
          cyc_q <= '0;
        end
      end
      if (rd_take) begin
        if (cyc_q[CB_IF]) fa_q <= addr;
        else if (!cyc_q[CB_DMA]) sec_q <= 1'b0;
        cyc_q <= '0;
      end
      if (wr_take) begin
        if (!cyc_q[CB_DMA]) sec_q <= 1'b0;
        cyc_q <= '0;
      end
      if (op_valid) begin
        cyc_q  <= '0;
        mref_q <= (opcode[14:12] != 3'b111);
        sec_q  <= 1'b1;
        f09_q  <= (fa_q[14:8] == 7'h09);
        if (mode_q[3] && mode_q[2])
          ovl_q <= recompute_zero ? 1'b0 : map_bit;
        if (mode_op) begin
          mode_q <= opcode[3:0];
          if (!opcode[3])      ovl_q <= 1'b0;
          else if (!opcode[2]) ovl_q <= 1'b1;
        end
      end
    end
  end

  // R7: mode opcode loads the register
  p_mode_load_r7: assert property (@(posedge clk) disable iff (rst)
    op_valid && mode_op |=> mode_q == $past(opcode[3:0]));
  // R5: opcode strobe marks the second access
  p_sec_set_r5: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> sec_q);
  // R5: a new fetch status clears the instruction flags
  p_fetch_clear_r5: assert property (@(posedge clk) disable iff (rst)
    stm_valid && stm_type[CB_IF] && !op_valid |=> !sec_q && !mref_q && !f09_q);
  // R7: option with bit 3 low clears overlay
  p_ovl_clear_r7: assert property (@(posedge clk) disable iff (rst)
    op_valid && mode_op && !opcode[3] |=> !ovl_q);
endmodule

// File: rtl/ovl_bank_sel.sv
module ovl_bank_sel
  import ovl_pkg::*;
#(
  parameter int MAP_AW = 12,
  parameter int MAP_DW = 8,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stm_valid,
  input  logic [4:0]        stm_type,
  input  logic [14:0]       addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_mask,
  input  logic              op_valid,
  input  logic [15:0]       opcode,
  input  logic              map_we,
  input  logic [MAP_AW-1:0] map_addr,
  input  logic [MAP_DW-1:0] map_wdata,
  output logic              rom_sel,
  output logic              ram_we,
  output logic [LANES-1:0]  ram_be
);
  logic              rd_d, wr_d, rd_rise, wr_rise;
  logic              rd_take, map_re, cyc_fetch, cyc_dma;
  logic [MODE_W-1:0] mode_q;
  logic              ovl_q, sec_q, mref_q, f09_q, dec_rom;
  logic [MAP_DW-1:0] map_q;
  logic              rom_q, we_q;
  logic [LANES-1:0]  be_q;

  assign rd_rise = rd_en && !rd_d;
  assign wr_rise = wr_en && !wr_d;

  ovl_map_ram #(.AW(MAP_AW), .DW(MAP_DW)) u_map (
    .clk(clk), .we(map_we), .waddr(map_addr), .wdata(map_wdata),
    .re(map_re), .raddr(~addr[MAP_AW-1:0]), .rdata(map_q)
  );

  ovl_ctrl #(.MAP_DW(MAP_DW)) u_ctrl (
    .clk(clk), .rst(rst), .stm_valid(stm_valid), .stm_type(stm_type),
    .addr(addr), .rd_rise(rd_rise), .wr_rise(wr_rise), .op_valid(op_valid),
    .opcode(opcode), .map_q(map_q), .rd_take(rd_take), .map_re(map_re),
    .cyc_fetch(cyc_fetch), .cyc_dma(cyc_dma), .mode_q(mode_q), .ovl_q(ovl_q),
    .sec_q(sec_q), .mref_q(mref_q), .f09_q(f09_q)
  );

  ovl_route_dec u_dec (
    .a(addr), .is_fetch(cyc_fetch), .is_dma(cyc_dma), .mode(mode_q),
    .ovl(ovl_q), .sec(sec_q), .mref(mref_q), .f09(f09_q), .to_rom(dec_rom)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_d  <= 1'b0;
      wr_d  <= 1'b0;
      rom_q <= 1'b0;
      we_q  <= 1'b0;
      be_q  <= '0;
    end else begin
      rd_d  <= rd_en;
      wr_d  <= wr_en;
      if (rd_take)     rom_q <= dec_rom;
      else if (!rd_en) rom_q <= 1'b0;
      we_q  <= wr_en;
      be_q  <= wr_en ? wr_mask : '0;
    end
  end

  assign rom_sel = rom_q;
  assign ram_we  = we_q;
  assign ram_be  = be_q;

  // R2: ROM select only while a read is in progress
  p_rom_needs_rd_r2: assert property (@(posedge clk) disable iff (rst)
    rom_q |-> rd_d);
  // R3: DMA reads never come from ROM
  p_dma_ram_r3: assert property (@(posedge clk) disable iff (rst)
    rd_take && cyc_dma |=> !rom_q);
  // R3: top window is RAM only
  p_top_ram_r3: assert property (@(posedge clk) disable iff (rst)
    rd_take && addr[14:13] == 2'b11 |=> !rom_q);
  // R11: write enable and lanes follow the strobe
  p_write_r11: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> we_q && be_q == $past(wr_mask));
endmodule

// File: tb/ovl_bank_sel_tb.sv
module ovl_bank_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stm_valid = 1'b0;
  logic [4:0]  stm_type = '0;
  logic [14:0] addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_mask = '0;
  logic        op_valid = 1'b0;
  logic [15:0] opcode = '0;
  logic        map_we = 1'b0;
  logic [11:0] map_addr = '0;
  logic [7:0]  map_wdata = '0;
  logic        rom_sel, ram_we;
  logic [1:0]  ram_be;

  int nchk = 0, nerr = 0, cyc = 0;
  logic r;

  always #10 clk = ~clk;

  ovl_bank_sel dut_i (
    .clk(clk), .rst(rst), .stm_valid(stm_valid), .stm_type(stm_type),
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wr_mask(wr_mask),
    .op_valid(op_valid), .opcode(opcode), .map_we(map_we),
    .map_addr(map_addr), .map_wdata(map_wdata), .rom_sel(rom_sel),
    .ram_we(ram_we), .ram_be(ram_be)
  );

  // {stm_type, addr, expected rom_sel}
  localparam logic [20:0] VEC [10] = '{
    {5'h01, 15'h0000, 1'b1}, {5'h01, 15'h03FF, 1'b1},
    {5'h01, 15'h0400, 1'b0}, {5'h01, 15'h2000, 1'b0},
    {5'h05, 15'h0800, 1'b1}, {5'h05, 15'h0400, 1'b0},
    {5'h05, 15'h6000, 1'b0}, {5'h09, 15'h0100, 1'b0},
    {5'h05, 15'h7FFF, 1'b0}, {5'h01, 15'h5FFF, 1'b0}
  };

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic stm(input logic [4:0] t);
    stm_valid = 1'b1; stm_type = t;
    @(negedge clk);
    stm_valid = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a, output logic res);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    res = rom_sel;
    rd_en = 1'b0;
  endtask

  task automatic op(input logic [15:0] o);
    opcode = o; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic fetch(input logic [14:0] a, input logic [15:0] o);
    logic dummy;
    stm(5'h05); rd(a, dummy); op(o);
  endtask

  task automatic dread(input logic [14:0] a, output logic res);
    stm(5'h01); rd(a, res);
  endtask

  task automatic mapw(input logic [11:0] i, input logic [7:0] d);
    map_we = 1'b1; map_addr = i; map_wdata = d;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nerr++;
        $display("FAIL watchdog actual %0d expected below 150000", cyc);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 4096; i++) mapw(i[11:0], 8'h00);  // R12 table load
    mapw(12'hDCB, 8'h40);  // fetch 0x1234 -> bit 6
    mapw(12'hEFF, 8'h02);  // fetch 0x6100 -> bit 1 (must be ignored)
    mapw(12'h6CB, 8'h80);  // fetch 0x0934 -> bit 7
    do_reset();

    // R1 reset state
    chk({1'b0, rom_sel}, 2'b00, "R1 rom_sel after reset");
    chk({ram_we, 1'b0}, 2'b00, "R1 ram_we after reset");
    chk(ram_be, 2'b00, "R1 ram_be after reset");

    // Table: R3 R4 R6 under reset mode
    for (int v = 0; v < 10; v++) begin
      stm(VEC[v][20:16]);
      rd(VEC[v][15:1], r);
      chk({1'b0, r}, {1'b0, VEC[v][0]}, $sformatf("vector %0d (R3 R4 R6)", v));
    end

    // R2 hold and release
    stm(5'h01); addr = 15'h0010; rd_en = 1'b1;
    @(negedge clk); chk({1'b0, rom_sel}, 2'b01, "R2 rom_sel first cycle");
    @(negedge clk); chk({1'b0, rom_sel}, 2'b01, "R2 rom_sel held");
    @(negedge clk); chk({1'b0, rom_sel}, 2'b01, "R2 rom_sel held again");
    rd_en = 1'b0;
    @(negedge clk); chk({1'b0, rom_sel}, 2'b00, "R2 rom_sel released");

    // R7 / R3 mode register
    do_reset();
    fetch(15'h0800, 16'h7045);
    dread(15'h0100, r); chk({1'b0, r}, 2'b00, "R3 mode bit1 low forces RAM");
    stm(5'h05); rd(15'h0800, r); chk({1'b0, r}, 2'b00, "R3 fetch with mode bit1 low");
    op(16'h704B);
    dread(15'h1000, r); chk({1'b0, r}, 2'b01, "R7 bit2 low sets overlay");
    dread(15'h0500, r); chk({1'b0, r}, 2'b01, "R6 mid window follows overlay when bit2 low");
    fetch(15'h0800, 16'h704A);
    dread(15'h1000, r); chk({1'b0, r}, 2'b00, "R3 mode bit0 low above 0x400");
    dread(15'h0200, r); chk({1'b0, r}, 2'b01, "R4 low window with bit0 low");
    fetch(15'h0800, 16'h7041);
    dread(15'h1000, r); chk({1'b0, r}, 2'b00, "R7 bit3 low clears overlay");

    // R5 second access
    do_reset();
    fetch(15'h0800, 16'h0000);
    dread(15'h1000, r); chk({1'b0, r}, 2'b01, "R5 second access forces ROM");
    dread(15'h1000, r); chk({1'b0, r}, 2'b00, "R5 flag cleared by data read");
    fetch(15'h0800, 16'h0000);
    dread(15'h0500, r); chk({1'b0, r}, 2'b00, "R5 mid window exempt with bit2 set");
    fetch(15'h0800, 16'h0000);
    stm(5'h11);
    dread(15'h1000, r); chk({1'b0, r}, 2'b00, "R5 register access clears flag");
    fetch(15'h0800, 16'h0000);
    stm(5'h09); rd(15'h1000, r); chk({1'b0, r}, 2'b00, "R3 DMA read is RAM");
    dread(15'h1000, r); chk({1'b0, r}, 2'b01, "R5 DMA read keeps flag");
    fetch(15'h0800, 16'h0000);
    stm(5'h02); wr_en = 1'b1; wr_mask = 2'b10;
    @(negedge clk);
    chk({ram_we, rom_sel}, 2'b10, "R11 write enable, no ROM");
    chk(ram_be, 2'b10, "R11 byte lanes");
    wr_en = 1'b0; wr_mask = 2'b00;
    @(negedge clk);
    chk({ram_we, 1'b0}, 2'b00, "R11 write enable drops");
    dread(15'h1000, r); chk({1'b0, r}, 2'b00, "R5 write clears flag");
    fetch(15'h0800, 16'h7000);
    dread(15'h1000, r); chk({1'b0, r}, 2'b00, "R5 non-mref opcode no force");

    // R8 overlay lookup
    do_reset();
    fetch(15'h1234, 16'h7000);
    dread(15'h1000, r); chk({1'b0, r}, 2'b01, "R8 map bit sets overlay");
    fetch(15'h1235, 16'h7000);
    dread(15'h1000, r); chk({1'b0, r}, 2'b00, "R8 zero map bit clears overlay");
    fetch(15'h1234, 16'h7000);
    fetch(15'h6100, 16'h7000);
    dread(15'h1000, r); chk({1'b0, r}, 2'b00, "R8 high fetch zeroes overlay");

    // R10 register-space fetch
    fetch(15'h1234, 16'h7000);
    stm(5'h15); rd(15'h0003, r); chk({1'b0, r}, 2'b00, "R10 register fetch read ignored");
    op(16'h7000);
    dread(15'h1000, r); chk({1'b0, r}, 2'b00, "R10 register fetch clears overlay");

    // R9 fetch in 0x09xx
    fetch(15'h0934, 16'h7000);
    dread(15'h0500, r); chk({1'b0, r}, 2'b01, "R9 overlay plus 09xx fetch forces ROM");
    fetch(15'h1234, 16'h7000);
    dread(15'h0500, r); chk({1'b0, r}, 2'b00, "R9 without 09xx fetch mid window RAM");

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule